// File: doc/BRIEF.md
# Inter-Processor Sync Register Pair

This block sits between two processors and gives each one a 16-bit synchronisation register. Both registers are decoded at the same I/O offset, and each processor reaches only its own register through its own halfword port. A processor uses its register to publish a 4-bit token to the other side and to read the token the other side published. It can also enable its own incoming interrupt and ring a doorbell toward the other side.

The two registers are cross-coupled. A write by one side stores the token and the enable bit in the writer's register and copies the token into the low nibble of the peer's register. If the doorbell bit of the written value is set and the peer has its interrupt enabled, the peer's interrupt output pulses for one cycle. The two ports work independently. When both sides write in the same cycle, both writes take effect, because they touch separate fields.

Top module: `ipc_sync_pair`

## Requirements
- R1: An access is decoded only when req is 1, size is 2'b01 (halfword; 2'b00 byte and 2'b10 word are not decoded) and addr equals SYNC_ADDR (default 0x04000180). Any other access changes no state, raises no interrupt, and returns rdata 0. rdata is 0 in every cycle without a decoded read.
- R2: A decoded read (we 0) returns the side's register in the same cycle. Bits 3:0 hold the token from the peer, bits 11:8 the side's own token and bit 14 its interrupt enable. Bits 15, 13, 12 and 7:4 read as 0.
- R3: A decoded write (we 1) loads wdata[11:8] into the writer's bits 11:8 and wdata[14] into its bit 14. Both are visible from the next cycle.
- R4: A decoded write loads wdata[11:8] into bits 3:0 of the peer's register, visible from the next cycle. The writer's own bits 3:0 are unchanged by its own write.
- R5: wdata[13] is a doorbell and is never stored. Bits 15, 13, 12 and 7:4 of wdata have no effect on either register.
- R6: A decoded write with wdata[13] set, while the peer's bit 14 is 1 before that edge, makes the peer's irq output 1 for exactly the next cycle. A write with bit 13 clear, or with the peer's bit 14 at 0, leaves the peer's irq at 0.
- R7: After reset both registers read 0 and both irq outputs are 0.
- R8: When both sides write in the same cycle, all four field updates take effect. Each doorbell is judged against the peer's enable as it was before that edge.
- R9: A side's doorbell never raises that side's own irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_req | input | 1 | Side A access request |
| a_we | input | 1 | Side A write (1) or read (0) |
| a_size | input | 2 | Side A access width: 00 byte, 01 halfword, 10 word |
| a_addr | input | ADDR_W | Side A address |
| a_wdata | input | 16 | Side A write data |
| a_rdata | output | 16 | Side A read data, 0 unless a decoded read |
| a_irq | output | 1 | Side A interrupt pulse |
| b_req | input | 1 | Side B access request |
| b_we | input | 1 | Side B write (1) or read (0) |
| b_size | input | 2 | Side B access width: 00 byte, 01 halfword, 10 word |
| b_addr | input | ADDR_W | Side B address |
| b_wdata | input | 16 | Side B write data |
| b_rdata | output | 16 | Side B read data, 0 unless a decoded read |
| b_irq | output | 1 | Side B interrupt pulse |

## Verification
A corrupted token or enable bit shows up at the first decoded read on either side after the bad edge. The read path is combinational, so the wrong value appears in the same cycle as the read. A wrong enable also shows one cycle after the next doorbell from the peer, as a pulse that is missing or should not be there. The reference model checks both read ports and both irq outputs in every cycle, including cycles with no decoded read. A mis-decoded byte, word or off-address access is therefore caught in the cycle it happens, as nonzero read data or as a token that changed.

// File: rtl/ipc_sync_pkg.sv
package ipc_sync_pkg;

   localparam int HALF_W   = 16;
   localparam int TOKEN_W  = 4;
   localparam int TOKEN_LO = 8;
   localparam int BELL_BIT = 13;
   localparam int IEN_BIT  = 14;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10
   } acc_size_e;

   typedef struct packed {
      logic               ien;
      logic [TOKEN_W-1:0] own_tok;
      logic [TOKEN_W-1:0] peer_tok;
   } sync_state_t;

   function automatic logic [HALF_W-1:0] view_of(input sync_state_t s);
      logic [HALF_W-1:0] v;
      v = '0;
      v[TOKEN_W-1:0]                = s.peer_tok;
      v[TOKEN_LO +: TOKEN_W]        = s.own_tok;
      v[IEN_BIT]                    = s.ien;
      return v;
   endfunction

endpackage

// File: rtl/ipc_access_decode.sv
module ipc_access_decode #(
   parameter int                ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] SYNC_ADDR = ADDR_W'(32'h0400_0180)
) (
   input  logic              req_i,
   input  logic              we_i,
   input  logic [1:0]        size_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              wr_hit_o,
   output logic              rd_hit_o
);
   import ipc_sync_pkg::*;

   if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_width
      $error("ipc_access_decode: ADDR_W out of range");
   end
   if (SYNC_ADDR[0] != 1'b0) begin : g_bad_align
      $error("ipc_access_decode: SYNC_ADDR must be halfword aligned");
   end

   logic sel;
   assign sel      = req_i && (size_i == SZ_HALF) && (addr_i == SYNC_ADDR);
   assign wr_hit_o = sel && we_i;
   assign rd_hit_o = sel && !we_i;

endmodule

// File: rtl/ipc_sync_side.sv
module ipc_sync_side
   import ipc_sync_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               own_wr_i,
   input  logic [TOKEN_W-1:0] own_tok_i,
   input  logic               own_ien_i,
   input  logic               peer_wr_i,
   input  logic [TOKEN_W-1:0] peer_tok_i,
   input  logic               peer_bell_i,
   output sync_state_t        state_o,
   output logic               irq_o
);

   sync_state_t state_q;
   logic        irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= '0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= peer_wr_i && peer_bell_i && state_q.ien;
         if (own_wr_i) begin
            state_q.own_tok <= own_tok_i;
            state_q.ien     <= own_ien_i;
         end
         if (peer_wr_i) begin
            state_q.peer_tok <= peer_tok_i;
         end
      end
   end

   assign state_o = state_q;
   assign irq_o   = irq_q;

endmodule

// File: rtl/ipc_read_view.sv
module ipc_read_view
   import ipc_sync_pkg::*;
(
   input  logic              rd_hit_i,
   input  sync_state_t       state_i,
   output logic [HALF_W-1:0] rdata_o
);
   assign rdata_o = rd_hit_i ? view_of(state_i) : '0;
endmodule

// File: rtl/ipc_sync_pair.sv
module ipc_sync_pair
   import ipc_sync_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] SYNC_ADDR = ADDR_W'(32'h0400_0180)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_req,
   input  logic              a_we,
   input  logic [1:0]        a_size,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [15:0]       a_wdata,
   output logic [15:0]       a_rdata,
   output logic              a_irq,
   input  logic              b_req,
   input  logic              b_we,
   input  logic [1:0]        b_size,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [15:0]       b_wdata,
   output logic [15:0]       b_rdata,
   output logic              b_irq
);
   localparam int SIDES = 2;

   logic [SIDES-1:0]             req_v, we_v, wr_hit, rd_hit, irq_v;
   logic [SIDES-1:0][1:0]        size_v;
   logic [SIDES-1:0][ADDR_W-1:0] addr_v;
   logic [SIDES-1:0][HALF_W-1:0] wd_v, rd_v;
   sync_state_t                  st [SIDES];

   assign req_v  = {b_req, a_req};
   assign we_v   = {b_we, a_we};
   assign size_v = {b_size, a_size};
   assign addr_v = {b_addr, a_addr};
   assign wd_v   = {b_wdata, a_wdata};

   logic unused_wbits;
   assign unused_wbits = ^{a_wdata[15], a_wdata[12], a_wdata[7:0],
                           b_wdata[15], b_wdata[12], b_wdata[7:0]};

   for (genvar s = 0; s < SIDES; s++) begin : g_side
      localparam int P = SIDES - 1 - s;

      ipc_access_decode #(.ADDR_W(ADDR_W), .SYNC_ADDR(SYNC_ADDR)) u_dec (
         .req_i    (req_v[s]),
         .we_i     (we_v[s]),
         .size_i   (size_v[s]),
         .addr_i   (addr_v[s]),
         .wr_hit_o (wr_hit[s]),
         .rd_hit_o (rd_hit[s])
      );

      ipc_sync_side u_reg (
         .clk         (clk),
         .rst_n       (rst_n),
         .own_wr_i    (wr_hit[s]),
         .own_tok_i   (wd_v[s][TOKEN_LO +: TOKEN_W]),
         .own_ien_i   (wd_v[s][IEN_BIT]),
         .peer_wr_i   (wr_hit[P]),
         .peer_tok_i  (wd_v[P][TOKEN_LO +: TOKEN_W]),
         .peer_bell_i (wd_v[P][BELL_BIT]),
         .state_o     (st[s]),
         .irq_o       (irq_v[s])
      );

      ipc_read_view u_view (
         .rd_hit_i (rd_hit[s]),
         .state_i  (st[s]),
         .rdata_o  (rd_v[s])
      );
   end

   assign a_rdata = rd_v[0];
   assign b_rdata = rd_v[1];
   assign a_irq   = irq_v[0];
   assign b_irq   = irq_v[1];

endmodule

// File: rtl/ipc_sync_chk.sv
module ipc_sync_chk #(
   parameter int                ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] SYNC_ADDR = ADDR_W'(32'h0400_0180)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              a_req,
   input logic              a_we,
   input logic [1:0]        a_size,
   input logic [ADDR_W-1:0] a_addr,
   input logic [3:0]        a_tok,
   input logic              a_ien,
   input logic              a_bell,
   input logic [15:0]       a_rdata,
   input logic              a_irq,
   input logic              b_req,
   input logic              b_we,
   input logic [1:0]        b_size,
   input logic [ADDR_W-1:0] b_addr,
   input logic [3:0]        b_tok,
   input logic              b_ien,
   input logic              b_bell,
   input logic [15:0]       b_rdata,
   input logic              b_irq
);
   logic a_sel, b_sel, a_wr, b_wr, a_rd, b_rd;
   assign a_sel = a_req && (a_size == 2'b01) && (a_addr == SYNC_ADDR);
   assign b_sel = b_req && (b_size == 2'b01) && (b_addr == SYNC_ADDR);
   assign a_wr  = a_sel && a_we;
   assign b_wr  = b_sel && b_we;
   assign a_rd  = a_sel && !a_we;
   assign b_rd  = b_sel && !b_we;

   // R6
   a_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_irq |-> $past(b_wr && b_bell));
   // R9
   b_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      b_irq |-> $past(a_wr && a_bell));
   // R2
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((a_rdata & 16'hB0F0) == 16'h0) && ((b_rdata & 16'hB0F0) == 16'h0));
   // R1
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_rd |-> a_rdata == 16'h0) and (!b_rd |-> b_rdata == 16'h0));
   // R4
   peer_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rd && $past(b_wr)) |-> a_rdata[3:0] == $past(b_tok));
   // R3
   own_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b_rd && $past(b_wr)) |-> (b_rdata[11:8] == $past(b_tok)) && (b_rdata[14] == $past(b_ien)));

endmodule

bind ipc_sync_pair ipc_sync_chk #(.ADDR_W(ADDR_W), .SYNC_ADDR(SYNC_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .a_req(a_req), .a_we(a_we), .a_size(a_size), .a_addr(a_addr),
   .a_tok(a_wdata[11:8]), .a_ien(a_wdata[14]), .a_bell(a_wdata[13]),
   .a_rdata(a_rdata), .a_irq(a_irq),
   .b_req(b_req), .b_we(b_we), .b_size(b_size), .b_addr(b_addr),
   .b_tok(b_wdata[11:8]), .b_ien(b_wdata[14]), .b_bell(b_wdata[13]),
   .b_rdata(b_rdata), .b_irq(b_irq)
);

// File: tb/ipc_sync_pair_test.sv
module ipc_sync_pair_test;
   localparam int          CLK_PERIOD = 10;
   localparam logic [31:0] SA = 32'h0400_0180;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        a_req = 0, a_we = 0, b_req = 0, b_we = 0;
   logic [1:0]  a_size = 0, b_size = 0;
   logic [31:0] a_addr = 0, b_addr = 0;
   logic [15:0] a_wdata = 0, b_wdata = 0;
   logic [15:0] a_rdata, b_rdata;
   logic        a_irq, b_irq;

   int  errors = 0, checks = 0;
   bit  done = 0;
   int  m_in[2], m_out[2], m_ien[2];
   bit  m_irq[2];

   always #(CLK_PERIOD/2) clk = ~clk;

   ipc_sync_pair uut (
      .clk(clk), .rst_n(rst_n),
      .a_req(a_req), .a_we(a_we), .a_size(a_size), .a_addr(a_addr),
      .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
      .b_req(b_req), .b_we(b_we), .b_size(b_size), .b_addr(b_addr),
      .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq)
   );

   function automatic int mview(int s);
      return (m_ien[s] << 14) | (m_out[s] << 8) | m_in[s];
   endfunction

   task automatic check(input int act, input int exp, input string tag, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%04h expected=%04h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic ar, input logic aw, input logic [1:0] as,
                       input logic [31:0] aa, input logic [15:0] ad,
                       input logic br, input logic bw, input logic [1:0] bs,
                       input logic [31:0] ba, input logic [15:0] bd,
                       input string tag);
      bit ahit, bhit, aw_hit, bw_hit;
      int na_irq, nb_irq;
      a_req = ar; a_we = aw; a_size = as; a_addr = aa; a_wdata = ad;
      b_req = br; b_we = bw; b_size = bs; b_addr = ba; b_wdata = bd;
      #1;
      ahit = ar && as == 2'b01 && aa == SA;
      bhit = br && bs == 2'b01 && ba == SA;
      check(int'(a_rdata), (ahit && !aw) ? mview(0) : 0, tag, "a_rdata");
      check(int'(b_rdata), (bhit && !bw) ? mview(1) : 0, tag, "b_rdata");
      check(int'(a_irq), int'(m_irq[0]), tag, "a_irq");
      check(int'(b_irq), int'(m_irq[1]), tag, "b_irq");
      @(posedge clk);
      aw_hit = ahit && aw;
      bw_hit = bhit && bw;
      na_irq = (bw_hit && bd[13] && m_ien[0] != 0) ? 1 : 0;
      nb_irq = (aw_hit && ad[13] && m_ien[1] != 0) ? 1 : 0;
      if (aw_hit) begin
         m_out[0] = int'(ad[11:8]); m_ien[0] = int'(ad[14]); m_in[1] = int'(ad[11:8]);
      end
      if (bw_hit) begin
         m_out[1] = int'(bd[11:8]); m_ien[1] = int'(bd[14]); m_in[0] = int'(bd[11:8]);
      end
      m_irq[0] = na_irq != 0;
      m_irq[1] = nb_irq != 0;
      @(negedge clk);
   endtask

   task automatic wa(input logic [15:0] d, input string t);
      step(1, 1, 2'b01, SA, d, 0, 0, 2'b00, 32'h0, 16'h0, t);
   endtask
   task automatic wb(input logic [15:0] d, input string t);
      step(0, 0, 2'b00, 32'h0, 16'h0, 1, 1, 2'b01, SA, d, t);
   endtask
   task automatic rd2(input string t);
      step(1, 0, 2'b01, SA, 16'h0, 1, 0, 2'b01, SA, 16'h0, t);
   endtask
   task automatic idle(input string t);
      step(0, 0, 2'b00, 32'h0, 16'h0, 0, 0, 2'b00, 32'h0, 16'h0, t);
   endtask

   initial begin
      for (int s = 0; s < 2; s++) begin
         m_in[s] = 0; m_out[s] = 0; m_ien[s] = 0; m_irq[s] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R7 reset state
      idle("R7");
      rd2("R7");
      // R3 own fields, R4 token crosses over
      wa(16'h4A00, "R3");
      rd2("R2 R4");
      // R5 doorbell and reserved write bits not stored, peer enable off
      wa(16'hFFFF, "R5");
      rd2("R5 R2");
      // R4 owner cannot change its own low nibble
      wa(16'h4F0C, "R4");
      rd2("R4");
      wb(16'h4300, "R3");
      rd2("R4");
      // R6 doorbell to enabled peer, R9 no self interrupt
      wa(16'h2500, "R6 R9");
      idle("R6 pulse");
      idle("R6 pulse end");
      // R6 peer disabled: no pulse
      wb(16'h2000, "R6 disabled");
      idle("R6 disabled");
      // R1 non-decoded accesses
      step(1, 1, 2'b00, SA, 16'h4F00, 1, 1, 2'b10, SA, 16'h4F00, "R1 size");
      step(1, 1, 2'b01, SA + 2, 16'h6900, 1, 0, 2'b01, SA + 4, 16'h0, "R1 addr");
      step(0, 1, 2'b01, SA, 16'h6900, 1, 0, 2'b00, SA, 16'h0, "R1 req");
      step(1, 0, 2'b10, SA, 16'h0, 0, 0, 2'b01, SA, 16'h0, "R1 read");
      rd2("R1 state kept");
      // R8 simultaneous writes, pre-edge enables
      step(1, 1, 2'b01, SA, 16'h6700, 1, 1, 2'b01, SA, 16'h6C00, "R8");
      rd2("R8");
      step(1, 1, 2'b01, SA, 16'h6100, 1, 1, 2'b01, SA, 16'h2200, "R8 bells");
      rd2("R8 after");
      // R6 back-to-back doorbells
      wb(16'h2000, "R6 b2b");
      wb(16'h2000, "R6 b2b");
      idle("R6 b2b");
      idle("R6 b2b");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule